// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Port

This block is the programming port of a frequency synthesizer. A controller drives three wires: a serial data line, a serial clock and a load strobe. One bit enters a shift register on every rising edge of the serial clock, most significant bit first. The last bit shifted in is an address bit. When the load strobe goes high, the address bit picks which of two holding registers takes the word. A 1 selects the reference word, which holds a 14-bit reference ratio and a prescaler-select bit. A 0 selects the feedback word, which holds an 8-bit swallow value and an 11-bit main count.

The three wires come from another clock domain. Each one passes through a two-stage synchronizer into the block clock `clk`, and the serial clock and load strobe are turned into single-cycle events. A word that would set a forbidden ratio is refused: the held value stays and an error flag is high for one cycle. While the strobe is high, a switch-enable output is driven. The loop filter uses it to shorten lock time during a channel change. The synchronizer that carries the strobe resets to high, as if the pin were pulled up. So a strobe that is high when reset is released turns the switch on and does not load anything.

Top module: `synth_serial_loader`

## Requirements
- R1: The shift register takes in one bit of `ser_data` for each rising edge of `ser_clk`. The level of `ser_data` while `ser_clk` stays high, or while it falls, has no effect.
- R2: A load whose last shifted bit is 1 writes the reference word. Counting from the last bit received (position 0), `ref_ratio` takes positions 14..1 and `presc_sel` takes position 15.
- R3: A load whose last shifted bit is 0 writes the feedback word. Counting the same way, `swallow` takes positions 8..1 and `main_cnt` takes positions 19..9. A swallow value of 0 is legal.
- R4: A reference load looks only at the last 16 bits shifted in, and a feedback load only at the last 20. Bits shifted in before those have no effect.
- R5: Only a low-to-high transition of `load_en` loads a word. While `load_en` stays high, shifting goes on and both held words keep their values.
- R6: A reference load with a ratio below 8 keeps the previous reference word and raises `ratio_err` for exactly one cycle. A ratio of exactly 8 is accepted.
- R7: A feedback load with a main count below 16 keeps the previous feedback word and raises `ratio_err` for exactly one cycle. A count of exactly 16 is accepted.
- R8: `sw_en` follows `load_en` two `clk` rising edges later.
- R9: After reset: `ref_ratio`=8, `presc_sel`=0, `swallow`=0, `main_cnt`=16, `ratio_err`=0 and `sw_en`=1. A `load_en` that is high at reset release loads nothing.
- R10: If `load_en` is driven high before `clk` edge k, the held word changes at edge k+2 and not earlier. A serial clock rise is taken in with the same delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; a rising edge shifts in one bit |
| ser_data | input | 1 | Serial data, MSB first, address bit last |
| load_en | input | 1 | Load strobe; a rising edge loads, high level enables the switch |
| sw_en | output | 1 | Fast-lock switch enable, synchronized `load_en` |
| ref_ratio | output | 14 | Held reference ratio |
| presc_sel | output | 1 | Held prescaler-select bit |
| swallow | output | 8 | Held swallow value |
| main_cnt | output | 11 | Held main count |
| ratio_err | output | 1 | One-cycle pulse when a load is refused |

## Verification
The bench sends reference and feedback words with different bit patterns, so a swapped or shifted field shows up in the held values. The boundary values 7, 8, 15 and 16 separate the accept path from the refuse path. Streams longer than a word show whether leftover leading bits leak into a field. A strobe held high while a new word shifts in separates edge-triggered loading from level-triggered loading, and data that changes while the serial clock is high shows whether the shifter samples on the edge or on the level.

// File: rtl/sl_pkg.sv
package sl_pkg;
  parameter int REF_W    = 14;
  parameter int SWAL_W   = 8;
  parameter int MAIN_W   = 11;
  parameter int MIN_REF  = 8;
  parameter int MIN_MAIN = 16;
  parameter int SYNC_STAGES = 2;

  localparam int REF_WORD_W = REF_W + 2;
  localparam int FB_WORD_W  = SWAL_W + MAIN_W + 1;
  localparam int SHIFT_W    = (REF_WORD_W > FB_WORD_W) ? REF_WORD_W : FB_WORD_W;

  typedef enum logic {DEST_FB = 1'b0, DEST_REF = 1'b1} dest_e;

  typedef struct packed {
    logic             presc;
    logic [REF_W-1:0] ratio;
  } ref_word_t;

  typedef struct packed {
    logic [MAIN_W-1:0] main;
    logic [SWAL_W-1:0] swal;
  } fb_word_t;

  function automatic dest_e word_dest(input logic [SHIFT_W-1:0] sr);
    return dest_e'(sr[0]);
  endfunction

  function automatic ref_word_t pick_ref(input logic [SHIFT_W-1:0] sr);
    ref_word_t w;
    w.ratio = sr[REF_W:1];
    w.presc = sr[REF_W+1];
    return w;
  endfunction

  function automatic fb_word_t pick_fb(input logic [SHIFT_W-1:0] sr);
    fb_word_t w;
    w.swal = sr[SWAL_W:1];
    w.main = sr[SWAL_W+MAIN_W:SWAL_W+1];
    return w;
  endfunction

  function automatic logic ref_legal(input ref_word_t w);
    return 32'(w.ratio) >= MIN_REF;
  endfunction

  function automatic logic fb_legal(input fb_word_t w);
    return 32'(w.main) >= MIN_MAIN;
  endfunction

  function automatic ref_word_t ref_reset();
    ref_word_t w;
    w.presc = 1'b0;
    w.ratio = REF_W'(MIN_REF);
    return w;
  endfunction

  function automatic fb_word_t fb_reset();
    fb_word_t w;
    w.swal = '0;
    w.main = MAIN_W'(MIN_MAIN);
    return w;
  endfunction
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[i] <= RST_VAL;
      else        pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sl_edge.sv
module sl_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= RST_VAL;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/sl_shifter.sv
module sl_shifter #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_evt,
  input  logic             bit_in,
  output logic [WIDTH-1:0] sr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sr <= '0;
    else if (shift_evt) sr <= {sr[WIDTH-2:0], bit_in};
  end
endmodule

// File: rtl/sl_word_bank.sv
module sl_word_bank
  import sl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_evt,
  input  logic [SHIFT_W-1:0] sr,
  output ref_word_t          ref_q,
  output fb_word_t           fb_q,
  output logic               err,
  output logic               ref_take,
  output logic               fb_take,
  output logic               reject
);
  dest_e     dest;
  ref_word_t ref_cand;
  fb_word_t  fb_cand;

  always_comb begin
    dest     = word_dest(sr);
    ref_cand = pick_ref(sr);
    fb_cand  = pick_fb(sr);
    ref_take = load_evt && (dest == DEST_REF) && ref_legal(ref_cand);
    fb_take  = load_evt && (dest == DEST_FB)  && fb_legal(fb_cand);
    reject   = load_evt && !ref_take && !fb_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= ref_reset();
      fb_q  <= fb_reset();
      err   <= 1'b0;
    end else begin
      if (ref_take) ref_q <= ref_cand;
      if (fb_take)  fb_q  <= fb_cand;
      err <= reject;
    end
  end
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
  import sl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              load_en,
  output logic              sw_en,
  output logic [REF_W-1:0]  ref_ratio,
  output logic              presc_sel,
  output logic [SWAL_W-1:0] swallow,
  output logic [MAIN_W-1:0] main_cnt,
  output logic              ratio_err
);
  localparam logic [2:0] SYNC_RST = 3'b100;

  logic [2:0]         sync_out;
  logic               le_s, dat_s, sck_s;
  logic               shift_evt, load_evt;
  logic [SHIFT_W-1:0] sr;
  ref_word_t          ref_q;
  fb_word_t           fb_q;
  logic               ref_take, fb_take, reject;

  sl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({load_en, ser_data, ser_clk}),
    .dout(sync_out)
  );
  assign {le_s, dat_s, sck_s} = sync_out;

  sl_edge #(.RST_VAL(1'b0)) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sck_s), .rise(shift_evt)
  );

  sl_edge #(.RST_VAL(1'b1)) u_le_edge (
    .clk(clk), .rst_n(rst_n), .lvl(le_s), .rise(load_evt)
  );

  sl_shifter #(.WIDTH(SHIFT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_evt(shift_evt), .bit_in(dat_s), .sr(sr)
  );

  sl_word_bank u_bank (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .sr(sr),
    .ref_q(ref_q), .fb_q(fb_q), .err(ratio_err),
    .ref_take(ref_take), .fb_take(fb_take), .reject(reject)
  );

  assign sw_en     = le_s;
  assign ref_ratio = ref_q.ratio;
  assign presc_sel = ref_q.presc;
  assign swallow   = fb_q.swal;
  assign main_cnt  = fb_q.main;
endmodule

// File: rtl/sl_checker.sv
module sl_checker
  import sl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               load_en,
  input logic               sw_en,
  input logic               load_evt,
  input logic               reject,
  input logic [SHIFT_W-1:0] sr,
  input logic [REF_W-1:0]   ref_ratio,
  input logic               presc_sel,
  input logic [SWAL_W-1:0]  swallow,
  input logic [MAIN_W-1:0]  main_cnt,
  input logic               ratio_err
);
  // R5: held words move only in the cycle after a load event
  assert_hold_without_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_evt) |-> ($stable(ref_ratio) && $stable(presc_sel) &&
                          $stable(swallow) && $stable(main_cnt)));

  // R6, R7: a refused load leaves both words untouched
  assert_reject_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |-> ($stable(ref_ratio) && $stable(presc_sel) &&
                   $stable(swallow) && $stable(main_cnt)));

  assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |=> !ratio_err);

  assert_err_follows_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> ratio_err);

  assert_ref_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ref_ratio) >= MIN_REF);

  assert_main_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(main_cnt) >= MIN_MAIN);

  // R3: feedback word changes only when the address bit was 0
  assert_fb_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(main_cnt) |-> !$past(sr[0]));

  // R2: reference word changes only when the address bit was 1
  assert_ref_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_ratio) |-> $past(sr[0]));

  // R8: switch enable tracks the strobe
  assert_sw_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> $past(load_en));

  assert_sw_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |-> !$past(load_en));
endmodule

bind synth_serial_loader sl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .sw_en(sw_en),
  .load_evt(load_evt), .reject(reject), .sr(sr),
  .ref_ratio(ref_ratio), .presc_sel(presc_sel), .swallow(swallow),
  .main_cnt(main_cnt), .ratio_err(ratio_err)
);

// File: tb/synth_serial_loader_tb.sv
module synth_serial_loader_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, load_en = 1'b1;
  logic sw_en, presc_sel, ratio_err;
  logic [13:0] ref_ratio;
  logic [7:0]  swallow;
  logic [10:0] main_cnt;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_serial_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .load_en(load_en), .sw_en(sw_en), .ref_ratio(ref_ratio),
    .presc_sel(presc_sel), .swallow(swallow), .main_cnt(main_cnt),
    .ratio_err(ratio_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit hc[4], hd[4], hl[4];
  bit q[$];
  int m_ref, m_presc, m_swal, m_main;
  bit m_err, m_sw;

  function automatic bit tail(int i);
    return (q.size() > i) ? q[q.size()-1-i] : 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin hc[i] = 0; hd[i] = 0; hl[i] = 1; end
      q.delete();
      m_ref = 8; m_presc = 0; m_swal = 0; m_main = 16; m_err = 0; m_sw = 1;
    end else begin
      for (int i = 3; i > 0; i--) begin
        hc[i] = hc[i-1]; hd[i] = hd[i-1]; hl[i] = hl[i-1];
      end
      hc[0] = ser_clk; hd[0] = ser_data; hl[0] = load_en;
      m_err = 0;
      if (hl[2] && !hl[3]) begin
        int r, a, n;
        r = 0; a = 0; n = 0;
        if (tail(0)) begin
          for (int j = 0; j < 14; j++) r += int'(tail(1+j)) << j;
          if (r >= 8) begin m_ref = r; m_presc = int'(tail(15)); end
          else m_err = 1;
        end else begin
          for (int j = 0; j < 8; j++)  a += int'(tail(1+j)) << j;
          for (int j = 0; j < 11; j++) n += int'(tail(9+j)) << j;
          if (n >= 16) begin m_swal = a; m_main = n; end
          else m_err = 1;
        end
      end
      if (hc[2] && !hc[3]) begin
        q.push_back(hd[2]);
        if (q.size() > 64) void'(q.pop_front());
      end
      m_sw = hl[1];
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R2 cyc ref_ratio", int'(ref_ratio), m_ref);
      chk("R2 cyc presc_sel", int'(presc_sel), m_presc);
      chk("R3 cyc swallow", int'(swallow), m_swal);
      chk("R3 cyc main_cnt", int'(main_cnt), m_main);
      chk("R6 cyc ratio_err", int'(ratio_err), int'(m_err));
      chk("R8 cyc sw_en", int'(sw_en), int'(m_sw));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic ser_bit(input bit b, input bit wiggle);
    ser_data = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    if (wiggle) begin
      ser_data = ~b;
      repeat (3) @(negedge clk);
    end
    ser_clk = 1'b0;
  endtask

  task automatic send(input logic [31:0] w, input int n, input bit wiggle);
    for (int i = n - 1; i >= 0; i--) ser_bit(w[i], wiggle);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_load();
    load_en = 1'b1;
    repeat (5) @(negedge clk);
    load_en = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [31:0] ref_word(input int ratio, input bit presc);
    return {16'd0, presc, 14'(ratio), 1'b1};
  endfunction

  function automatic logic [31:0] fb_word(input int a, input int n);
    return {12'd0, 11'(n), 8'(a), 1'b0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values while in reset
    chk("R9 reset ref_ratio", int'(ref_ratio), 8);
    chk("R9 reset main_cnt", int'(main_cnt), 16);
    chk("R9 reset swallow", int'(swallow), 0);
    chk("R9 reset err", int'(ratio_err), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 no load from high strobe at release", int'(ref_ratio), 8);
    chk("R9 sw_en high at release", int'(sw_en), 1);
    load_en = 1'b0;
    repeat (4) @(negedge clk);

    // R1, R2: reference word
    send(ref_word(1000, 1), 16, 0);
    pulse_load();
    chk("R2 ref ratio 1000", int'(ref_ratio), 1000);
    chk("R2 presc_sel 1", int'(presc_sel), 1);

    // R3: feedback word, with data changing while ser_clk high (R1)
    send(fb_word(37, 500), 20, 1);
    pulse_load();
    chk("R1 R3 swallow 37", int'(swallow), 37);
    chk("R3 main 500", int'(main_cnt), 500);
    chk("R3 ref untouched", int'(ref_ratio), 1000);

    // R6, R7 boundaries: accepted
    send(ref_word(8, 0), 16, 0);
    pulse_load();
    chk("R6 ratio 8 accepted", int'(ref_ratio), 8);
    send(fb_word(0, 16), 20, 0);
    pulse_load();
    chk("R7 main 16 accepted", int'(main_cnt), 16);
    chk("R3 swallow 0 accepted", int'(swallow), 0);

    // R6: ratio 7 refused, err for one cycle
    send(ref_word(7, 1), 16, 0);
    @(negedge clk); load_en = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R6 err pulse", int'(ratio_err), 1);
    @(posedge clk); #1;
    chk("R6 err one cycle", int'(ratio_err), 0);
    chk("R6 ratio kept", int'(ref_ratio), 8);
    chk("R6 presc kept", int'(presc_sel), 0);
    @(negedge clk); load_en = 1'b0; repeat (5) @(negedge clk);

    // R7: main 15 refused
    send(fb_word(99, 15), 20, 0);
    pulse_load();
    chk("R7 main kept", int'(main_cnt), 16);
    chk("R7 swallow kept", int'(swallow), 0);

    // R4: excess leading bits
    send(32'h3FF, 10, 0);
    send(fb_word(200, 2047), 20, 0);
    pulse_load();
    chk("R4 long stream swallow", int'(swallow), 200);
    chk("R4 long stream main", int'(main_cnt), 2047);
    send(32'h15, 5, 0);
    send(ref_word(16383, 0), 16, 0);
    pulse_load();
    chk("R4 long stream ratio", int'(ref_ratio), 16383);

    // R5: level held high does not reload
    load_en = 1'b1;
    repeat (5) @(negedge clk);
    send(ref_word(300, 1), 16, 0);
    repeat (5) @(negedge clk);
    chk("R5 held strobe no reload", int'(ref_ratio), 16383);
    load_en = 1'b0;
    repeat (5) @(negedge clk);
    pulse_load();
    chk("R5 fresh edge loads", int'(ref_ratio), 300);

    // R10, R8: exact latency
    send(ref_word(4321, 0), 16, 0);
    @(negedge clk); load_en = 1'b1;
    @(posedge clk); #1;
    chk("R8 sw_en not yet", int'(sw_en), 0);
    @(posedge clk); #1;
    chk("R8 sw_en after two edges", int'(sw_en), 1);
    chk("R10 not updated at k+1", int'(ref_ratio), 300);
    @(posedge clk); #1;
    chk("R10 updated at k+2", int'(ref_ratio), 4321);
    @(negedge clk); load_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 sw_en low", int'(sw_en), 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule